// File: doc/BRIEF.md
# Multi-Mode Base Timer

A free-running counter whose steps come from a programmable clock prescaler or, in quadrature mode, from the edges of two phase inputs. In up mode it wraps at full scale. In triangle mode it climbs to full scale and descends back to zero. In quadrature mode every valid edge of either phase moves it by one, and the direction follows the phase order.

The count returns to zero when any of several enabled events occurs: a compare match, a low level on a synchronized external clear pin, or a carry out of either the top bit or a lower tap bit. Software can overwrite the count while the timer runs. A one-cycle interrupt pulse marks a carry out of one of three tap bits, chosen by a select code. Dropping the run bit holds everything at zero.

Top module: `base_timer`

## Requirements
- R1: While `run` is 0 the count is cleared on the next clock edge and `irq` stays 0. The prescaler also holds at zero, so after reset `count` reads 0.
- R2: Outside quadrature mode the counter steps once every 2(n+1) clocks, where n is `presc_code`. When n is all ones it steps on every clock. Once `run` is set, the first step lands on exactly the 2(n+1)-th rising edge.
- R3: `mode` code 0 (and the spare code 3) counts up by one per step and wraps from all ones to 0.
- R4: With `match_rst_en` set, in up or quadrature mode, a step taken while `count` equals `cmp_val` produces 0 instead of the neighbouring value.
- R5: `mode` code 1 counts up to all ones, then down to 0, then up again. The extremes are held for one step each.
- R6: In `mode` 1 with `match_rst_en` set and a nonzero `cmp_val`, an upward step taken at `count == cmp_val` reverses direction and gives `cmp_val-1`.
- R7: `mode` code 2 ignores the prescaler. Taking {phase_a,phase_b} through 00,10,11,01 adds one per change, and the reverse order subtracts one. A change of both phases at once leaves the count alone. The count shows a phase change three edges after it is applied.
- R8: With `ovf_rst_en` set, a carry out of the selected bit clears the count. `ovf_rst_sel` 0 selects the top bit and 1 selects tap bit LO_TAP.
- R9: With `ext_rst_en` set, a low `ext_rst_n` passes through a two-flop synchronizer and then holds the count at 0. The first cleared value appears on the third edge. With `ext_rst_en` clear, the pin has no effect.
- R10: `irq` is a one-cycle pulse, shown in the same cycle as the stepped count, for each upward step that carries out of the selected tap. `irq_sel` 0 selects LO_TAP, 1 selects MID_TAP, and 2 or 3 select the top bit.
- R11: A write while running loads `wr_data` on the next edge, in place of any step. Counting then continues from the loaded value.
- R12: A write while `run` is 0 is discarded, and a later start begins from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 1 counts, 0 holds at zero |
| mode | input | 2 | 0 up, 1 triangle, 2 quadrature, 3 up |
| presc_code | input | CODE_W | Prescale code n |
| match_rst_en | input | 1 | Enables compare match action |
| cmp_val | input | WIDTH | Compare value |
| ovf_rst_en | input | 1 | Enables clear on carry |
| ovf_rst_sel | input | 1 | 0 top bit, 1 LO_TAP |
| ext_rst_en | input | 1 | Enables the external clear pin |
| ext_rst_n | input | 1 | Asynchronous active-low clear pin |
| irq_sel | input | 2 | Interrupt tap select |
| wr_en | input | 1 | Software load strobe |
| wr_data | input | WIDTH | Value to load |
| phase_a | input | 1 | Quadrature phase A |
| phase_b | input | 1 | Quadrature phase B |
| count | output | WIDTH | Current count |
| irq | output | 1 | Carry interrupt pulse |

## Verification
The bench builds the timer with WIDTH 8, LO_TAP 3 and MID_TAP 6, keeping the prescale code at 5 bits. With an 8-bit count, full wraps, complete triangle periods and every interrupt tap are reached within a few hundred steps, so the sweeps cover every count value in both directions. All 32 prescale codes are swept, including the undivided code. The expected count and pulse are computed from the step index by modulo and triangle arithmetic.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic [1:0] {
    BT_UP   = 2'd0,
    BT_TRI  = 2'd1,
    BT_QUAD = 2'd2,
    BT_SPARE = 2'd3
  } bt_mode_e;

  // Clocks between count steps for prescale code n.
  function automatic int unsigned presc_period(input int unsigned code,
                                               input int unsigned code_w);
    int unsigned top;
    top = (1 << code_w) - 1;
    return (code == top) ? 1 : 2 * (code + 1);
  endfunction

  // Phase order 00 -> 10 -> 11 -> 01 (bits {a,b}) counts up.
  // Result bit 0 = step up, bit 1 = step down.
  function automatic logic [1:0] quad_move(input logic [1:0] prev,
                                           input logic [1:0] cur);
    logic [1:0] r;
    r = 2'b00;
    unique case ({prev, cur})
      4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: r = 2'b01;
      4'b10_00, 4'b11_10, 4'b01_11, 4'b00_01: r = 2'b10;
      default:                                r = 2'b00;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bt_sync.sv
module bt_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  logic [N-1:0] meta_q, safe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      safe_q <= RST_VAL;
    end else begin
      meta_q <= din;
      safe_q <= meta_q;
    end
  end

  assign dout = safe_q;

endmodule

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);

  localparam int CNT_W = CODE_W + 2;

  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] period;

  always_comb begin
    period = CNT_W'(bt_pkg::presc_period(int'(code), CODE_W));
  end

  // >= so that a code lowered mid-period still wraps promptly
  assign tick = run && (div_q >= period - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             div_q <= '0;
    else if (!run || tick)  div_q <= '0;
    else                    div_q <= div_q + CNT_W'(1);
  end

endmodule

// File: rtl/bt_quad.sv
module bt_quad (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] ab,
  output logic       q_up,
  output logic       q_dn
);

  logic [1:0] prev_q;
  logic [1:0] move;

  always_comb move = bt_pkg::quad_move(prev_q, ab);

  assign q_up = run && move[0];
  assign q_dn = run && move[1];

  // prev follows the inputs even when idle, so a start never sees a stale edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b00;
    else        prev_q <= ab;
  end

endmodule

// File: rtl/bt_core.sv
module bt_core #(
  parameter int WIDTH   = 16,
  parameter int LO_TAP  = 9,
  parameter int MID_TAP = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       mode,
  input  logic             tick,
  input  logic             q_up,
  input  logic             q_dn,
  input  logic             match_en,
  input  logic [WIDTH-1:0] cmp,
  input  logic             ovf_en,
  input  logic             ovf_sel,
  input  logic             ext_clr,
  input  logic [1:0]       irq_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] cnt,
  output logic             irq
);
  import bt_pkg::*;

  localparam int NTAP = 3;
  localparam int TAP_BIT [NTAP] = '{LO_TAP, MID_TAP, WIDTH - 1};
  localparam logic [WIDTH-1:0] ALL1 = {WIDTH{1'b1}};

  bt_mode_e   m;
  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic       dir_q, dir_d;            // 1 = descending (triangle mode)
  logic       step_up, step_dn;
  logic       turn_dn, turn_up, going_dn;
  logic [NTAP-1:0] carry;
  logic       ovf_hit, match_hit, irq_hit;

  always_comb m = bt_mode_e'(mode);

  // Triangle turn points
  assign turn_dn  = !dir_q && (cnt_q == ALL1 ||
                    (match_en && cnt_q == cmp && cnt_q != '0));
  assign turn_up  = dir_q && (cnt_q == '0);
  assign going_dn = turn_dn || (dir_q && !turn_up);

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    dir_d   = dir_q;
    unique case (m)
      BT_TRI: begin
        step_up = tick && !going_dn;
        step_dn = tick && going_dn;
        if (tick) dir_d = going_dn;
      end
      BT_QUAD: begin
        step_up = q_up;
        step_dn = q_dn;
      end
      default: begin
        step_up = tick;
        dir_d   = 1'b0;
      end
    endcase
  end

  // Carry out of each tap bit on an upward step
  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam logic [WIDTH-1:0] MASK = ALL1 >> (WIDTH - 1 - TAP_BIT[g]);
    assign carry[g] = step_up && ((cnt_q & MASK) == MASK);
  end

  assign ovf_hit   = ovf_en && (ovf_sel ? carry[0] : carry[2]);
  assign match_hit = match_en && (m != BT_TRI) && (step_up || step_dn) &&
                     (cnt_q == cmp);

  always_comb begin
    unique case (irq_sel)
      2'd0:    irq_hit = carry[0];
      2'd1:    irq_hit = carry[1];
      default: irq_hit = carry[2];
    endcase
  end

  always_comb begin
    if (ovf_hit || match_hit) cnt_d = '0;
    else if (step_up)         cnt_d = cnt_q + WIDTH'(1);
    else if (step_dn)         cnt_d = cnt_q - WIDTH'(1);
    else                      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      irq   <= 1'b0;
    end else if (!run || ext_clr) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      irq   <= 1'b0;
    end else if (wr_en) begin
      cnt_q <= wr_data;
      irq   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      irq   <= irq_hit;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/base_timer.sv
module base_timer #(
  parameter int WIDTH   = 16,
  parameter int CODE_W  = 5,
  parameter int LO_TAP  = 9,   // must be below MID_TAP
  parameter int MID_TAP = 14   // must be below WIDTH-1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [1:0]        mode,
  input  logic [CODE_W-1:0] presc_code,
  input  logic              match_rst_en,
  input  logic [WIDTH-1:0]  cmp_val,
  input  logic              ovf_rst_en,
  input  logic              ovf_rst_sel,
  input  logic              ext_rst_en,
  input  logic              ext_rst_n,
  input  logic [1:0]        irq_sel,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              phase_a,
  input  logic              phase_b,
  output logic [WIDTH-1:0]  count,
  output logic              irq
);

  // Named internal events, visible to the bound checker
  logic [2:0] pins_s;
  logic       tick;
  logic       ext_clr;
  logic       q_up, q_dn;

  bt_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({ext_rst_n, phase_a, phase_b}),
    .dout (pins_s)
  );

  assign ext_clr = ext_rst_en && !pins_s[2];

  bt_prescaler #(.CODE_W(CODE_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .code (presc_code),
    .tick (tick)
  );

  bt_quad u_quad (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .ab   (pins_s[1:0]),
    .q_up (q_up),
    .q_dn (q_dn)
  );

  bt_core #(.WIDTH(WIDTH), .LO_TAP(LO_TAP), .MID_TAP(MID_TAP)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .mode    (mode),
    .tick    (tick),
    .q_up    (q_up),
    .q_dn    (q_dn),
    .match_en(match_rst_en),
    .cmp     (cmp_val),
    .ovf_en  (ovf_rst_en),
    .ovf_sel (ovf_rst_sel),
    .ext_clr (ext_clr),
    .irq_sel (irq_sel),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cnt     (count),
    .irq     (irq)
  );

endmodule

// File: rtl/bt_checker.sv
module bt_checker #(
  parameter int WIDTH  = 16,
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              wr_en,
  input logic [WIDTH-1:0]  wr_data,
  input logic [CODE_W-1:0] presc_code,
  input logic [WIDTH-1:0]  count,
  input logic              irq,
  input logic              tick,
  input logic              ext_clr
);

  a_r1_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == '0) && !irq);

  a_r1_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || presc_code == '1));

  a_r9_ext_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ext_clr) |=> (count == '0));

  a_r11_write_load: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en && !ext_clr) |=> (count == $past(wr_data)));

  a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

endmodule

bind base_timer bt_checker #(.WIDTH(WIDTH), .CODE_W(CODE_W)) u_bt_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .presc_code(presc_code),
  .count     (count),
  .irq       (irq),
  .tick      (tick),
  .ext_clr   (ext_clr)
);

// File: tb/test_base_timer.sv
`timescale 1ns/1ps
module test_base_timer;

  localparam int W = 8;
  localparam int CW = 5;
  localparam int LO = 3;
  localparam int MID = 6;
  localparam logic [1:0] GRAY [4] = '{2'b00, 2'b10, 2'b11, 2'b01};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [CW-1:0] presc_code = '1;
  logic match_rst_en = 1'b0;
  logic [W-1:0] cmp_val = '0;
  logic ovf_rst_en = 1'b0, ovf_rst_sel = 1'b0;
  logic ext_rst_en = 1'b0, ext_rst_n = 1'b1;
  logic [1:0] irq_sel = 2'd0;
  logic wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic phase_a = 1'b0, phase_b = 1'b0;
  logic [W-1:0] count;
  logic irq;

  int n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  base_timer #(.WIDTH(W), .CODE_W(CW), .LO_TAP(LO), .MID_TAP(MID)) i_base_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .presc_code(presc_code),
    .match_rst_en(match_rst_en), .cmp_val(cmp_val), .ovf_rst_en(ovf_rst_en),
    .ovf_rst_sel(ovf_rst_sel), .ext_rst_en(ext_rst_en), .ext_rst_n(ext_rst_n),
    .irq_sel(irq_sel), .wr_en(wr_en), .wr_data(wr_data), .phase_a(phase_a),
    .phase_b(phase_b), .count(count), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg(input int md, input int code, input bit men, input int cmpv,
                     input bit oen, input bit osel, input int isel);
    @(negedge clk);
    run = 1'b0; wr_en = 1'b0;
    mode = 2'(md); presc_code = CW'(code); match_rst_en = men;
    cmp_val = W'(cmpv); ovf_rst_en = oen; ovf_rst_sel = osel; irq_sel = 2'(isel);
    @(negedge clk);
  endtask

  // kind 0: count = k mod per; kind 1: triangle with peak per
  task automatic sweep(input string req, input int kind, input int per,
                       input int ncyc, input int irqb);
    int e_cnt, p, e_irq;
    @(negedge clk);
    run = 1'b1;
    for (int k = 1; k <= ncyc; k++) begin
      @(negedge clk);
      p = 0;
      if (kind == 0) e_cnt = k % per;
      else begin
        p = k % (2 * per);
        e_cnt = (p <= per) ? p : 2 * per - p;
      end
      chk(req, int'(count), e_cnt);
      if (irqb >= 0) begin
        if (kind == 0) e_irq = ((k % (1 << (irqb + 1))) == 0) ? 1 : 0;
        else e_irq = (p >= 1 && p <= per && (p % (1 << (irqb + 1))) == 0) ? 1 : 0;
        chk({req, "/R10 irq"}, int'(irq), e_irq);
      end
    end
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset count", int'(count), 0);
    chk("R1 reset irq", int'(irq), 0);

    // R2: every prescale code, first step timing
    for (int n = 0; n < 32; n++) begin
      int per;
      per = (n == 31) ? 1 : 2 * (n + 1);
      cfg(0, n, 0, 0, 0, 0, 0);
      run = 1'b1;
      for (int k = 1; k <= per; k++) begin
        @(negedge clk);
        if (k == per - 1) chk("R2 before first step", int'(count), 0);
        if (k == per)     chk("R2 first step", int'(count), 1);
      end
    end

    // R3 + R10: up mode, each interrupt tap
    cfg(0, 31, 0, 0, 0, 0, 0); sweep("R3 up tap lo", 0, 256, 300, LO);
    cfg(0, 31, 0, 0, 0, 0, 1); sweep("R3 up tap mid", 0, 256, 300, MID);
    cfg(0, 31, 0, 0, 0, 0, 2); sweep("R3 up tap top", 0, 256, 300, W - 1);
    cfg(3, 31, 0, 0, 0, 0, 3); sweep("R3 spare code", 0, 256, 270, W - 1);

    // R2: divided rate sweep (code 2 -> period 6)
    cfg(0, 2, 0, 0, 0, 0, 2);
    @(negedge clk); run = 1'b1;
    for (int k = 1; k <= 120; k++) begin
      @(negedge clk);
      chk("R2 divided rate", int'(count), k / 6);
    end
    @(negedge clk); run = 1'b0;

    // R4: match clear in up mode
    cfg(0, 31, 1, 0, 0, 0, 0);   sweep("R4 match 0", 0, 1, 20, -1);
    cfg(0, 31, 1, 5, 0, 0, 0);   sweep("R4 match 5", 0, 6, 40, -1);
    cfg(0, 31, 1, 37, 0, 0, 0);  sweep("R4 match 37", 0, 38, 120, -1);
    cfg(0, 31, 1, 200, 0, 0, 0); sweep("R4 match 200", 0, 201, 300, -1);

    // R8: carry clear
    cfg(0, 31, 0, 0, 1, 1, 0); sweep("R8 clear at lo tap", 0, 16, 100, LO);
    cfg(0, 31, 0, 0, 1, 0, 2); sweep("R8 clear at top", 0, 256, 300, W - 1);

    // R5 / R6: triangle
    cfg(1, 31, 0, 0, 0, 0, 0);   sweep("R5 triangle", 1, 255, 1100, LO);
    cfg(1, 31, 1, 20, 0, 0, 0);  sweep("R6 turn at 20", 1, 20, 100, -1);
    cfg(1, 31, 1, 100, 0, 0, 0); sweep("R6 turn at 100", 1, 100, 450, -1);

    // R7: quadrature
    begin
      int s, q;
      cfg(2, 31, 0, 0, 0, 0, 0);
      phase_a = 1'b0; phase_b = 1'b0;
      run = 1'b1;
      s = 0; q = 0;
      repeat (10) @(negedge clk);
      chk("R7 prescaler ignored", int'(count), 0);
      for (int i = 0; i < 20; i++) begin
        s = (s + 1) % 4; {phase_a, phase_b} = GRAY[s];
        repeat (3) @(negedge clk);
        q = (q + 1) % 256;
        chk("R7 forward order", int'(count), q);
      end
      for (int i = 0; i < 25; i++) begin
        s = (s + 3) % 4; {phase_a, phase_b} = GRAY[s];
        repeat (3) @(negedge clk);
        q = (q + 255) % 256;
        chk("R7 reverse order", int'(count), q);
      end
      s = (s + 2) % 4; {phase_a, phase_b} = GRAY[s];
      repeat (3) @(negedge clk);
      chk("R7 double change", int'(count), q);
      repeat (3) @(negedge clk);
      chk("R7 double change held", int'(count), q);
      s = (s + 1) % 4; {phase_a, phase_b} = GRAY[s];
      repeat (2) @(negedge clk);
      chk("R7 latency not yet", int'(count), q);
      @(negedge clk);
      q = (q + 1) % 256;
      chk("R7 latency three edges", int'(count), q);
      run = 1'b0;
      @(negedge clk);
      chk("R1 stop clears", int'(count), 0);
      phase_a = 1'b0; phase_b = 1'b0;
      repeat (4) @(negedge clk);
    end

    // R9: external clear
    cfg(0, 31, 0, 0, 0, 0, 0);
    run = 1'b1;
    repeat (50) @(negedge clk);
    chk("R9 pre clear", int'(count), 50);
    ext_rst_en = 1'b1; ext_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 sync delay", int'(count), 52);
    @(negedge clk);
    chk("R9 cleared", int'(count), 0);
    repeat (10) @(negedge clk);
    chk("R9 held", int'(count), 0);
    ext_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 release", int'(count), 1);
    repeat (9) @(negedge clk);
    chk("R9 resumes", int'(count), 10);
    ext_rst_en = 1'b0; ext_rst_n = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9 disabled pin", int'(count), 30);
    ext_rst_n = 1'b1;

    // R11: write while running
    wr_en = 1'b1; wr_data = 8'd200;
    @(negedge clk);
    chk("R11 load", int'(count), 200);
    wr_en = 1'b0;
    @(negedge clk);
    chk("R11 continue", int'(count), 201);
    wr_en = 1'b1; wr_data = 8'd15; irq_sel = 2'd0;
    @(negedge clk);
    chk("R11 load beats step", int'(count), 15);
    chk("R11 no irq on load", int'(irq), 0);
    wr_en = 1'b0;
    @(negedge clk);
    chk("R11 step after load", int'(count), 16);
    chk("R10 carry after load", int'(irq), 1);
    run = 1'b0;
    @(negedge clk);
    chk("R1 stop", int'(count), 0);
    chk("R1 stop irq", int'(irq), 0);

    // R12: write while stopped
    cfg(0, 4, 0, 0, 0, 0, 0);
    wr_en = 1'b1; wr_data = 8'hAA;
    repeat (2) @(negedge clk);
    chk("R12 idle write", int'(count), 0);
    wr_en = 1'b0; run = 1'b1;
    repeat (9) @(negedge clk);
    chk("R12 start from zero", int'(count), 0);
    @(negedge clk);
    chk("R12 first step", int'(count), 1);
    run = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1-sequence: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule